// File: doc/BRIEF.md
# Luma Blanking Split and Pedestal Stage

This block sits in a video decoder's output path, after the luma/chroma separation. Each decoded luma sample has a blanking reference subtracted from it. The sign of that difference decides what the sample is. A negative difference is a mixed-sync sample. It goes to a sync output after a fixed delay. A zero or positive difference is picture luma. An 8-bit pedestal is removed from it, and the result can optionally be clipped at zero so that super-black excursions are dropped.

The blanking reference comes from one of four places, picked by a 2-bit select:
- a fixed level of 240;
- a fixed level of 256;
- an external per-sample blanking input;
- a held copy of low-pass-filtered luma, sampled on the rising edge of a back-porch gate.

Both outputs leave the block in the same cycle, together with a valid strobe and a flag that marks which path holds the sample. The output on the other path is zero.

Top module: `luma_blank_ped`

## Requirements
- R1: With `ref_sel` = 0 the blanking reference is 240. With `ref_sel` = 1 it is 256.
- R2: With `ref_sel` = 2 the reference is the `ext_blank` value presented with the same sample.
- R3: With `ref_sel` = 3 the reference is a held register. It takes the value of `lpf_luma` in the cycle where `clamp_gate` is high after being low. That sample still uses the old value. The register reads 240 after reset. Changes on `lpf_luma` while the gate stays high or stays low have no effect.
- R4: When luma minus reference is negative, `is_sync` = 1, `sync_out` equals the difference, and `luma_out` = 0.
- R5: When the difference is zero or positive, `is_sync` = 0, `sync_out` = 0, and `luma_out` equals the difference minus `pedestal`.
- R6: When the pedestal result of R5 is negative, `luma_out` is 0 if `superblack_pass` = 0. It is the negative value if `superblack_pass` = 1.
- R7: Every output, including `out_valid`, appears exactly SYNC_DLY+1 cycles after its input sample (3 cycles by default). Cycles where `in_valid` = 0 yield `out_valid` = 0.
- R8: After reset, `out_valid`, `is_sync`, `sync_out` and `luma_out` are all 0.
- R9: The difference is kept at DW+1 signed bits, so the extremes +1023 (luma 1023, reference 0) and −1023 (luma 0, reference 1023) keep their sign and magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| luma_in | input | DW | Decoded luma sample, unsigned |
| ref_sel | input | 2 | Reference select: 0 = 240, 1 = 256, 2 = external, 3 = captured filtered luma |
| ext_blank | input | DW | External blanking level |
| lpf_luma | input | DW | Low-pass-filtered luma, captured on the gate's rising edge |
| clamp_gate | input | 1 | Back-porch capture gate |
| pedestal | input | PW | Pedestal subtracted on the luma path |
| superblack_pass | input | 1 | 1 passes negative pedestal results; 0 clips them to zero |
| out_valid | output | 1 | Output sample strobe |
| is_sync | output | 1 | 1 marks a sync sample, 0 a luma sample |
| sync_out | output | DW+1 | Signed mixed-sync sample, zero on luma samples |
| luma_out | output | DW+1 | Signed pedestal-stripped luma, zero on sync samples |

## Verification
A wrong held reference shows up only while `ref_sel` = 3. It then shifts every output sample by a constant offset, SYNC_DLY+1 cycles after the first sample that uses it. A stale or early capture shows up on the first sample after a gate rising edge. A misplaced sign decision shows up in the same latency as samples on the wrong path: `is_sync` flips, and a nonzero value appears on the path that should be zero. A delay mismatch between the two paths shows up as valid strobes or luma values that are shifted by whole cycles against the sync values.

// File: rtl/lbp_pkg.sv
package lbp_pkg;
   typedef enum logic [1:0] {
      REF_FIX_LO = 2'd0,
      REF_FIX_HI = 2'd1,
      REF_EXT    = 2'd2,
      REF_HELD   = 2'd3
   } ref_sel_e;

   localparam int unsigned FIX_LO_LEVEL = 240;
   localparam int unsigned FIX_HI_LEVEL = 256;
   localparam int unsigned MIN_DW       = 9;
endpackage

// File: rtl/lbp_delay_line.sv
module lbp_delay_line #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign q_o = d_i;
      end else begin : g_regs
         logic [W-1:0] stage_q [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(DEPTH); i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d_i;
               for (int i = 1; i < int'(DEPTH); i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q_o = stage_q[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/lbp_ref_select.sv
module lbp_ref_select
   import lbp_pkg::*;
#(
   parameter int unsigned DW       = 10,
   parameter int unsigned CAP_INIT = 240
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sel_i,
   input  logic [DW-1:0] ext_i,
   input  logic [DW-1:0] lpf_i,
   input  logic          gate_i,
   output logic [DW-1:0] ref_o
);
   localparam logic [DW-1:0] LO_REF   = DW'(FIX_LO_LEVEL);
   localparam logic [DW-1:0] HI_REF   = DW'(FIX_HI_LEVEL);
   localparam logic [DW-1:0] INIT_REF = DW'(CAP_INIT);

   logic          gate_q;
   logic [DW-1:0] held_q;
   logic          gate_rise;
   ref_sel_e      sel;

   assign gate_rise = gate_i & ~gate_q;
   assign sel       = ref_sel_e'(sel_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         held_q <= INIT_REF;
      end else begin
         gate_q <= gate_i;
         if (gate_rise) held_q <= lpf_i;
      end
   end

   always_comb begin
      unique case (sel)
         REF_FIX_LO: ref_o = LO_REF;
         REF_FIX_HI: ref_o = HI_REF;
         REF_EXT:    ref_o = ext_i;
         REF_HELD:   ref_o = held_q;
         default:    ref_o = LO_REF;
      endcase
   end
endmodule

// File: rtl/lbp_splitter.sv
module lbp_splitter #(
   parameter int unsigned DW = 10,
   parameter int unsigned PW = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid_i,
   input  logic [DW-1:0]       luma_i,
   input  logic [DW-1:0]       ref_i,
   input  logic [PW-1:0]       ped_i,
   input  logic                sb_i,
   output logic                valid_o,
   output logic                is_sync_o,
   output logic signed [DW:0]  sync_o,
   output logic signed [DW:0]  pos_o,
   output logic [PW-1:0]       ped_o,
   output logic                sb_o
);
   logic signed [DW:0] diff;
   logic               neg;

   assign diff = $signed({1'b0, luma_i}) - $signed({1'b0, ref_i});
   assign neg  = diff[DW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o   <= 1'b0;
         is_sync_o <= 1'b0;
         sync_o    <= '0;
         pos_o     <= '0;
         ped_o     <= '0;
         sb_o      <= 1'b0;
      end else begin
         valid_o   <= valid_i;
         is_sync_o <= neg;
         sync_o    <= neg ? diff : '0;
         pos_o     <= neg ? '0 : diff;
         ped_o     <= ped_i;
         sb_o      <= sb_i;
      end
   end
endmodule

// File: rtl/lbp_pedestal.sv
module lbp_pedestal #(
   parameter int unsigned DW = 10,
   parameter int unsigned PW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               is_sync_i,
   input  logic signed [DW:0] pos_i,
   input  logic [PW-1:0]      ped_i,
   input  logic               sb_i,
   output logic signed [DW:0] luma_o
);
   logic signed [DW:0] stripped;
   logic signed [DW:0] shaped;

   assign stripped = pos_i - $signed({{(DW+1-PW){1'b0}}, ped_i});

   always_comb begin
      if (is_sync_i)                     shaped = '0;
      else if (stripped[DW] && !sb_i)    shaped = '0;
      else                               shaped = stripped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) luma_o <= '0;
      else        luma_o <= shaped;
   end
endmodule

// File: rtl/luma_blank_ped.sv
module luma_blank_ped
   import lbp_pkg::*;
#(
   parameter int unsigned DW       = 10,
   parameter int unsigned PW       = 8,
   parameter int unsigned SYNC_DLY = 2,
   parameter int unsigned CAP_INIT = 240
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [DW-1:0]      luma_in,
   input  logic [1:0]         ref_sel,
   input  logic [DW-1:0]      ext_blank,
   input  logic [DW-1:0]      lpf_luma,
   input  logic               clamp_gate,
   input  logic [PW-1:0]      pedestal,
   input  logic               superblack_pass,
   output logic               out_valid,
   output logic               is_sync,
   output logic signed [DW:0] sync_out,
   output logic signed [DW:0] luma_out
);
   localparam int unsigned SW       = DW + 1;
   localparam int unsigned TAG_W    = SW + 2;
   localparam int unsigned LUMA_DLY = SYNC_DLY - 1;

   if (DW < MIN_DW) begin : g_chk_dw
      $error("luma_blank_ped: DW must hold the fixed 256 reference");
   end
   if (PW < 1 || PW > DW) begin : g_chk_pw
      $error("luma_blank_ped: PW must be between 1 and DW");
   end
   if (SYNC_DLY < 1) begin : g_chk_dly
      $error("luma_blank_ped: SYNC_DLY must be at least 1");
   end
   if (CAP_INIT >= (1 << DW)) begin : g_chk_init
      $error("luma_blank_ped: CAP_INIT does not fit DW bits");
   end

   logic [DW-1:0]      ref_lvl;
   logic               a_valid, a_sync, a_sb;
   logic signed [DW:0] a_sync_val, a_pos;
   logic [PW-1:0]      a_ped;
   logic signed [DW:0] b_luma;
   logic [TAG_W-1:0]   tag_d, tag_q;
   logic [SW-1:0]      luma_q;

   lbp_ref_select #(.DW(DW), .CAP_INIT(CAP_INIT)) u_ref (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (ref_sel),
      .ext_i  (ext_blank),
      .lpf_i  (lpf_luma),
      .gate_i (clamp_gate),
      .ref_o  (ref_lvl)
   );

   lbp_splitter #(.DW(DW), .PW(PW)) u_split (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (in_valid),
      .luma_i    (luma_in),
      .ref_i     (ref_lvl),
      .ped_i     (pedestal),
      .sb_i      (superblack_pass),
      .valid_o   (a_valid),
      .is_sync_o (a_sync),
      .sync_o    (a_sync_val),
      .pos_o     (a_pos),
      .ped_o     (a_ped),
      .sb_o      (a_sb)
   );

   assign tag_d = {a_valid, a_sync, a_sync_val};

   lbp_delay_line #(.W(TAG_W), .DEPTH(SYNC_DLY)) u_sync_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (tag_d),
      .q_o   (tag_q)
   );

   lbp_pedestal #(.DW(DW), .PW(PW)) u_ped (
      .clk       (clk),
      .rst_n     (rst_n),
      .is_sync_i (a_sync),
      .pos_i     (a_pos),
      .ped_i     (a_ped),
      .sb_i      (a_sb),
      .luma_o    (b_luma)
   );

   lbp_delay_line #(.W(SW), .DEPTH(LUMA_DLY)) u_luma_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (b_luma),
      .q_o   (luma_q)
   );

   assign out_valid = tag_q[TAG_W-1];
   assign is_sync   = tag_q[TAG_W-2];
   assign sync_out  = $signed(tag_q[SW-1:0]);
   assign luma_out  = $signed(luma_q);
endmodule

// File: rtl/lbp_checker.sv
module lbp_checker #(
   parameter int unsigned DW       = 10,
   parameter int unsigned PW       = 8,
   parameter int unsigned SYNC_DLY = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [DW-1:0]      luma_in,
   input logic [1:0]         ref_sel,
   input logic               superblack_pass,
   input logic               out_valid,
   input logic               is_sync,
   input logic signed [DW:0] sync_out,
   input logic signed [DW:0] luma_out
);
   localparam int unsigned LAT = SYNC_DLY + 1;

   logic p_valid [LAT];
   logic p_known [LAT];
   logic p_sync  [LAT];
   logic p_sb    [LAT];

   logic known_now, sync_now;
   always_comb begin
      known_now = (ref_sel == 2'd0) || (ref_sel == 2'd1);
      sync_now  = (ref_sel == 2'd0) ? (int'(luma_in) < 240) : (int'(luma_in) < 256);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(LAT); i++) begin
            p_valid[i] <= 1'b0;
            p_known[i] <= 1'b0;
            p_sync[i]  <= 1'b0;
            p_sb[i]    <= 1'b0;
         end
      end else begin
         p_valid[0] <= in_valid;
         p_known[0] <= known_now;
         p_sync[0]  <= sync_now;
         p_sb[0]    <= superblack_pass;
         for (int i = 1; i < int'(LAT); i++) begin
            p_valid[i] <= p_valid[i-1];
            p_known[i] <= p_known[i-1];
            p_sync[i]  <= p_sync[i-1];
            p_sb[i]    <= p_sb[i-1];
         end
      end
   end

   a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == p_valid[LAT-1]);

   a_r1_fixed_split: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && p_known[LAT-1]) |-> (is_sync == p_sync[LAT-1]));

   a_r4_sync_negative: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && is_sync) |-> (sync_out < 0 && luma_out == 0));

   a_r5_luma_path_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !is_sync) |-> (sync_out == 0));

   a_r6_clip_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !is_sync && !p_sb[LAT-1]) |-> (luma_out >= 0));
endmodule

bind luma_blank_ped lbp_checker #(.DW(DW), .PW(PW), .SYNC_DLY(SYNC_DLY)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .in_valid        (in_valid),
   .luma_in         (luma_in),
   .ref_sel         (ref_sel),
   .superblack_pass (superblack_pass),
   .out_valid       (out_valid),
   .is_sync         (is_sync),
   .sync_out        (sync_out),
   .luma_out        (luma_out)
);

// File: tb/sim_luma_blank_ped.sv
module sim_luma_blank_ped;
   localparam int DW  = 10;
   localparam int PW  = 8;
   localparam int DLY = 2;
   localparam int LAT = DLY + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [DW-1:0] luma_in = '0;
   logic [1:0] ref_sel = '0;
   logic [DW-1:0] ext_blank = '0;
   logic [DW-1:0] lpf_luma = '0;
   logic clamp_gate = 1'b0;
   logic [PW-1:0] pedestal = '0;
   logic superblack_pass = 1'b0;
   logic out_valid, is_sync;
   logic signed [DW:0] sync_out, luma_out;

   always #5 clk = ~clk;

   luma_blank_ped #(.DW(DW), .PW(PW), .SYNC_DLY(DLY)) u0 (.*);

   typedef struct {
      bit    v;
      bit    s;
      int    sy;
      int    lu;
      string tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int failures = 0;
   int held_ref = 240;
   bit gate_prev = 1'b0;
   bit done = 1'b0;

   task automatic check_out();
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.v) begin
         if (!(out_valid === 1'b1 && is_sync === e.s && sync_out == e.sy && luma_out == e.lu)) begin
            failures++;
            $display("FAIL %s: got v=%0b s=%0b sync=%0d luma=%0d exp s=%0b sync=%0d luma=%0d",
                     e.tag, out_valid, is_sync, sync_out, luma_out, e.s, e.sy, e.lu);
         end
      end else if (out_valid !== 1'b0) begin
         failures++;
         $display("FAIL %s: got out_valid=%0b exp 0", e.tag, out_valid);
      end
   endtask

   task automatic step(input bit v, input int lum, input int sel, input int ext,
                       input int lpf, input bit gate, input int ped, input bit sb,
                       input string extra);
      exp_t e;
      int r, d, p;
      @(negedge clk);
      check_out();
      in_valid = v; luma_in = lum[DW-1:0]; ref_sel = sel[1:0];
      ext_blank = ext[DW-1:0]; lpf_luma = lpf[DW-1:0]; clamp_gate = gate;
      pedestal = ped[PW-1:0]; superblack_pass = sb;
      case (sel)
         0: r = 240;
         1: r = 256;
         2: r = ext;
         default: r = held_ref;
      endcase
      d = lum - r;
      e.v = v;
      if (d < 0) begin
         e.s = 1'b1; e.sy = d; e.lu = 0;
         e.tag = "R4";
      end else begin
         p = d - ped;
         e.tag = "R5";
         if (p < 0) begin
            e.tag = "R6";
            if (!sb) p = 0;
         end
         e.s = 1'b0; e.sy = 0; e.lu = p;
      end
      case (sel)
         0, 1: e.tag = {e.tag, " R1"};
         2: e.tag = {e.tag, " R2"};
         default: e.tag = {e.tag, " R3"};
      endcase
      if (!v) e.tag = "R7 idle";
      e.tag = {e.tag, " ", extra};
      q.push_back(e);
      if (gate && !gate_prev) held_ref = lpf;
      gate_prev = gate;
   endtask

   task automatic sweep(input int sel, input int ped, input bit sb);
      int lpf_v = 300;
      bit g = 1'b0;
      for (int l = 0; l < 1024; l += 9) begin
         if (sel == 3 && (l % 90) == 0) begin
            g = ~g;
            lpf_v = (lpf_v * 5 + 77) % 1024;
         end
         step(1'b1, l, sel, (l * 7 + 13) % 1024, (sel == 3) ? lpf_v + (l % 3) : l, g, ped, sb, "sweep");
         if ((l % 45) == 0) step(1'b0, 0, sel, 0, lpf_v, g, ped, sb, "gap");
      end
      step(1'b1, 1023, sel, 512, lpf_v, g, ped, sb, "top");
   endtask

   initial begin
      int peds [3] = '{0, 60, 255};
      for (int i = 0; i < LAT; i++) begin
         exp_t e;
         e.v = 1'b0; e.s = 1'b0; e.sy = 0; e.lu = 0; e.tag = "R7 fill";
         q.push_back(e);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (!(out_valid === 1'b0 && is_sync === 1'b0 && sync_out == 0 && luma_out == 0)) begin
         failures++;
         $display("FAIL R8: got v=%0b s=%0b sync=%0d luma=%0d exp all 0",
                  out_valid, is_sync, sync_out, luma_out);
      end
      rst_n = 1'b1;
      // R3: held reference reads 240 before any gate edge
      step(1'b1, 239, 3, 0, 900, 1'b0, 0, 1'b0, "R3 init");
      step(1'b1, 240, 3, 0, 900, 1'b0, 0, 1'b0, "R3 init");
      // R3: gate rise captures; that sample uses old value; held gate ignores lpf
      step(1'b1, 500, 3, 0, 400, 1'b1, 0, 1'b0, "R3 edge");
      step(1'b1, 500, 3, 0, 100, 1'b1, 0, 1'b0, "R3 hold");
      step(1'b1, 399, 3, 0, 100, 1'b0, 0, 1'b0, "R3 low");
      // R9 extremes
      step(1'b1, 1023, 2, 0, 0, 1'b0, 0, 1'b0, "R9 max");
      step(1'b1, 0, 2, 1023, 0, 1'b0, 0, 1'b0, "R9 min");
      step(1'b1, 1023, 2, 0, 0, 1'b0, 255, 1'b1, "R9 ped");
      // R6 pass of negative pedestal result
      step(1'b1, 250, 0, 0, 0, 1'b0, 255, 1'b1, "R6 pass");
      step(1'b1, 250, 0, 0, 0, 1'b0, 255, 1'b0, "R6 clip");
      for (int s = 0; s < 4; s++)
         for (int pi = 0; pi < 3; pi++)
            for (int b = 0; b < 2; b++)
               sweep(s, peds[pi], b[0]);
      for (int i = 0; i < LAT; i++) step(1'b0, 0, 0, 0, 0, 1'b0, 0, 1'b0, "drain");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule